// File: doc/BRIEF.md
# I2C Start / Repeated-Start Condition Sequencer

This block produces the opening condition of an I2C transfer on open-drain SDA and SCL lines. It handles both a fresh Start from an idle bus and a Repeated Start in the middle of a transfer. It never drives a line high. It only raises a drive-low enable for each line and reads the real line levels back through a synchronizer. Phase lengths come from an external rollover divider. The sequencer tells that divider when to reload and when to run. Between phases the divider stays suspended, so a slave that holds SCL low stretches the sequence instead of shortening it.

A one-cycle request pulse sets an internal request bit, and that bit clears itself when the sequence ends. Every phase checks the line levels it expects. On any mismatch the sequence gives up, releases both lines, pulses a bus-collision flag and returns to idle. A separate detector reports every Start edge it sees on the bus, whoever made it. While a sequence is under way, writes to the transmit buffer are refused and flagged as write collisions.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset both drive-low enables are 0, both request bits are 0, the divider run output is 0, and all flag pulses are 0.
- R2: A start pulse in idle sets the start request bit. If both synchronized lines read high, the divider reloads and runs for one period. If both lines still read high at its rollover, SDA is driven low while SCL is released, no earlier than one divider period after the request.
- R3: Once SDA is driven low, the divider reloads for one more period. At that rollover, done pulses for one cycle, the request bit clears, the divider stops running, SDA stays driven low and SCL stays released.
- R4: If either line reads low when a start is checked, the block pulses bus collision, releases both lines, clears the request bit and gives no done pulse.
- R5: If SCL reads low during the high setup period, before SDA is driven low, the block pulses bus collision and aborts to idle.
- R6: A repeated-start pulse in idle first drives SCL low and leaves SDA unchanged. Once SCL reads low, SDA is released and the divider runs for one period.
- R7: At the end of the SDA-release period, if SDA reads high, SCL is released. The divider stays suspended until SCL reads high, so stretching lengthens the phase. The sequence then runs a high setup period and a SDA-low period, pulses done and clears the repeated-start bit. It ends with SDA driven low and SCL released.
- R8: During a repeated start, the block pulses bus collision and aborts if SDA reads low at the end of the release period or when SCL is seen rising.
- R9: Start or repeated-start pulses that arrive while a sequence or abort is in progress are ignored. When both pulses arrive together in idle, start wins. The two request bits are never set at the same time.
- R10: A buffer write strobe while the block is busy gives a one-cycle write-collision pulse and is not forwarded. In idle it is forwarded as a one-cycle accepted-write pulse, one clock after the strobe.
- R11: The start-seen output pulses once for each falling SDA edge that occurs while SCL is high, including edges made by other devices. An SDA fall while SCL is low gives no pulse.
- R12: Line inputs pass through SYNC_STAGES flip-flops, so start-seen rises SYNC_STAGES+1 clocks after the line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | One-cycle Start request |
| rstart_set | input | 1 | One-cycle Repeated Start request |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| brg_tick | input | 1 | Divider rollover pulse |
| buf_wr | input | 1 | Transmit buffer write strobe |
| sda_low | output | 1 | Drive SDA low (open drain) |
| scl_low | output | 1 | Drive SCL low (open drain) |
| brg_reload | output | 1 | Reload the divider this cycle |
| brg_run | output | 1 | Divider allowed to count (0 = suspended) |
| start_bit | output | 1 | Start request pending, clears itself at the end |
| rstart_bit | output | 1 | Repeated Start request pending, clears itself at the end |
| start_seen | output | 1 | Pulse on a Start edge detected on the bus |
| done_irq | output | 1 | Pulse when a sequence completes |
| bus_coll | output | 1 | Pulse when a sequence aborts on a line mismatch |
| wcol | output | 1 | Pulse when a buffer write is refused |
| buf_wr_ok | output | 1 | Pulse when a buffer write is accepted |

## Verification
The properties assume the following about the inputs. Request pulses last one cycle. The divider pulses its rollover only while run is high, and never in a reload cycle. Each divider period is longer than the synchronizer latency, so a level the block has just released is seen before the next rollover is judged. The bench's divider model reloads to a fixed period and suppresses the tick while reloading. Its slave model changes line levels only at falling clock edges and holds each change for several periods. Collisions are produced by a slave that holds a line at a chosen phase, and clock stretching by holding SCL after the master lets it go.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SCL_DOWN,
    ST_SDA_REL,
    ST_SCL_UP,
    ST_SETUP_HIGH,
    ST_DRIVE_SDA_LOW,
    ST_HOLD,
    ST_COLL_ABORT
  } seq_state_t;

  // Phases during which the divider is allowed to count.
  function automatic logic divider_runs(input seq_state_t s);
    return (s == ST_SETUP_HIGH) || (s == ST_DRIVE_SDA_LOW) ||
           (s == ST_HOLD) || (s == ST_SDA_REL);
  endfunction

  // Phases that begin with a fresh divider load.
  function automatic logic divider_loads(input seq_state_t s);
    return (s == ST_SETUP_HIGH) || (s == ST_DRIVE_SDA_LOW) ||
           (s == ST_SDA_REL);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_raw,
  input  logic scl_raw,
  output logic sda_s,
  output logic scl_s,
  output logic start_edge
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sda_q;
  logic [LAST:0] scl_q;
  logic          sda_prev;

  // Idle bus is high: reset the chains to 1 so that no edge appears at reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= '1;
      scl_q <= '1;
    end else begin
      sda_q[0] <= sda_raw;
      scl_q[0] <= scl_raw;
      for (int i = 1; i < STAGES; i++) begin
        sda_q[i] <= sda_q[i-1];
        scl_q[i] <= scl_q[i-1];
      end
    end
  end

  assign sda_s = sda_q[LAST];
  assign scl_s = scl_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev   <= 1'b1;
      start_edge <= 1'b0;
    end else begin
      sda_prev   <= sda_s;
      start_edge <= sda_prev & ~sda_s & scl_s;
    end
  end

endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_set,
  input  logic rstart_set,
  input  logic sda_s,
  input  logic scl_s,
  input  logic brg_tick,
  output logic sda_low,
  output logic scl_low,
  output logic brg_reload,
  output logic brg_run,
  output logic start_bit,
  output logic rstart_bit,
  output logic done_irq,
  output logic bus_coll,
  output logic busy
);
  seq_state_t state, nxt;
  logic       coll, fin, take_s, take_r;

  always_comb begin
    nxt    = state;
    coll   = 1'b0;
    fin    = 1'b0;
    take_s = 1'b0;
    take_r = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_set) begin
          take_s = 1'b1;
          nxt    = ST_CHECK;
        end else if (rstart_set) begin
          take_r = 1'b1;
          nxt    = ST_SCL_DOWN;
        end
      end
      ST_CHECK: begin
        if (sda_s && scl_s) nxt = ST_SETUP_HIGH;
        else                coll = 1'b1;
      end
      ST_SCL_DOWN: begin
        if (!scl_s) nxt = ST_SDA_REL;
      end
      ST_SDA_REL: begin
        if (brg_tick) begin
          if (sda_s) nxt = ST_SCL_UP;
          else       coll = 1'b1;
        end
      end
      ST_SCL_UP: begin
        if (scl_s) begin
          if (sda_s) nxt = ST_SETUP_HIGH;
          else       coll = 1'b1;
        end
      end
      ST_SETUP_HIGH: begin
        if (!scl_s) coll = 1'b1;
        else if (brg_tick) begin
          if (sda_s) nxt = ST_DRIVE_SDA_LOW;
          else       coll = 1'b1;
        end
      end
      ST_DRIVE_SDA_LOW: nxt = ST_HOLD;
      ST_HOLD: begin
        if (brg_tick) begin
          fin = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_COLL_ABORT: nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
    if (coll) nxt = ST_COLL_ABORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sda_low    <= 1'b0;
      scl_low    <= 1'b0;
      brg_reload <= 1'b0;
      brg_run    <= 1'b0;
      start_bit  <= 1'b0;
      rstart_bit <= 1'b0;
      done_irq   <= 1'b0;
      bus_coll   <= 1'b0;
    end else begin
      state      <= nxt;
      brg_reload <= (nxt != state) && divider_loads(nxt);
      brg_run    <= divider_runs(nxt);
      done_irq   <= fin;
      bus_coll   <= coll;

      if (nxt == ST_COLL_ABORT || nxt == ST_SDA_REL) sda_low <= 1'b0;
      else if (nxt == ST_DRIVE_SDA_LOW)              sda_low <= 1'b1;

      if (nxt == ST_SCL_DOWN)                            scl_low <= 1'b1;
      else if (nxt == ST_SCL_UP || nxt == ST_COLL_ABORT) scl_low <= 1'b0;

      if (take_s)          start_bit <= 1'b1;
      else if (fin || coll) start_bit <= 1'b0;

      if (take_r)          rstart_bit <= 1'b1;
      else if (fin || coll) rstart_bit <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2c_wr_guard.sv
module i2c_wr_guard (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic buf_wr,
  output logic wcol,
  output logic buf_wr_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wcol      <= 1'b0;
      buf_wr_ok <= 1'b0;
    end else begin
      wcol      <= buf_wr & busy;
      buf_wr_ok <= buf_wr & ~busy;
    end
  end
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_set,
  input  logic rstart_set,
  input  logic sda_in,
  input  logic scl_in,
  input  logic brg_tick,
  input  logic buf_wr,
  output logic sda_low,
  output logic scl_low,
  output logic brg_reload,
  output logic brg_run,
  output logic start_bit,
  output logic rstart_bit,
  output logic start_seen,
  output logic done_irq,
  output logic bus_coll,
  output logic wcol,
  output logic buf_wr_ok
);
  logic sda_s, scl_s, busy;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sda_raw    (sda_in),
    .scl_raw    (scl_in),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .start_edge (start_seen)
  );

  i2c_start_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_set  (start_set),
    .rstart_set (rstart_set),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .brg_tick   (brg_tick),
    .sda_low    (sda_low),
    .scl_low    (scl_low),
    .brg_reload (brg_reload),
    .brg_run    (brg_run),
    .start_bit  (start_bit),
    .rstart_bit (rstart_bit),
    .done_irq   (done_irq),
    .bus_coll   (bus_coll),
    .busy       (busy)
  );

  i2c_wr_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .buf_wr    (buf_wr),
    .wcol      (wcol),
    .buf_wr_ok (buf_wr_ok)
  );

endmodule

// File: rtl/i2c_start_seq_chk.sv
module i2c_start_seq_chk (
  input logic clk,
  input logic rst,
  input logic sda_low,
  input logic scl_low,
  input logic brg_reload,
  input logic brg_run,
  input logic start_bit,
  input logic rstart_bit,
  input logic done_irq,
  input logic bus_coll,
  input logic wcol,
  input logic buf_wr_ok,
  input logic busy
);
  p_sda_edge_scl_free_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_low);

  p_done_holds_lines_r3: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (sda_low && !scl_low && !brg_run));

  p_done_clears_req_r3: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (!start_bit && !rstart_bit));

  p_coll_releases_r4: assert property (@(posedge clk) disable iff (rst)
    bus_coll |-> (!sda_low && !scl_low && !start_bit && !rstart_bit));

  p_scl_before_sda_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low) |-> $stable(sda_low));

  p_reload_runs_r7: assert property (@(posedge clk) disable iff (rst)
    brg_reload |-> brg_run);

  p_req_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_bit, rstart_bit}));

  p_end_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_irq, bus_coll}));

  p_wcol_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    wcol |-> ($past(busy) && !buf_wr_ok));
endmodule

bind i2c_start_seq i2c_start_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sda_low    (sda_low),
  .scl_low    (scl_low),
  .brg_reload (brg_reload),
  .brg_run    (brg_run),
  .start_bit  (start_bit),
  .rstart_bit (rstart_bit),
  .done_irq   (done_irq),
  .bus_coll   (bus_coll),
  .wcol       (wcol),
  .buf_wr_ok  (buf_wr_ok),
  .busy       (busy)
);

// File: tb/i2c_start_seq_tb.sv
`timescale 1ns/1ps
module i2c_start_seq_tb;
  localparam int SYNC = 2;
  localparam int PER  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_set = 1'b0, rstart_set = 1'b0, buf_wr = 1'b0;
  logic slv_sda = 1'b0, slv_scl = 1'b0;
  logic sda_line, scl_line, brg_tick;
  logic sda_low, scl_low, brg_reload, brg_run, start_bit, rstart_bit;
  logic start_seen, done_irq, bus_coll, wcol, buf_wr_ok;
  logic [3:0] dcnt;

  int n_chk = 0, n_fail = 0;
  int n_seen = 0, n_done = 0, n_coll = 0, n_wcol = 0, n_wrok = 0;

  always #2 clk = ~clk;

  assign sda_line = ~(sda_low | slv_sda);
  assign scl_line = ~(scl_low | slv_scl);

  // Divider model: reload to PER-1, count while running, tick at zero.
  always @(posedge clk) begin
    if (rst) dcnt <= '0;
    else if (brg_reload) dcnt <= 4'(PER - 1);
    else if (brg_run) dcnt <= (dcnt == 0) ? 4'(PER - 1) : dcnt - 4'd1;
  end
  assign brg_tick = brg_run && !brg_reload && (dcnt == 0);

  i2c_start_seq #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .start_set(start_set), .rstart_set(rstart_set),
    .sda_in(sda_line), .scl_in(scl_line), .brg_tick(brg_tick), .buf_wr(buf_wr),
    .sda_low(sda_low), .scl_low(scl_low), .brg_reload(brg_reload),
    .brg_run(brg_run), .start_bit(start_bit), .rstart_bit(rstart_bit),
    .start_seen(start_seen), .done_irq(done_irq), .bus_coll(bus_coll),
    .wcol(wcol), .buf_wr_ok(buf_wr_ok)
  );

  always @(negedge clk) begin
    if (start_seen) n_seen++;
    if (done_irq)   n_done++;
    if (bus_coll)   n_coll++;
    if (wcol)       n_wcol++;
    if (buf_wr_ok)  n_wrok++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slv_sda = 1'b0; slv_scl = 1'b0;
    start_set = 1'b0; rstart_set = 1'b0; buf_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_set = 1'b1; @(negedge clk); start_set = 1'b0;
  endtask

  task automatic pulse_rstart();
    rstart_set = 1'b1; @(negedge clk); rstart_set = 1'b0;
  endtask

  task automatic wait_end(input int base_done, input int base_coll);
    for (int k = 0; k < 400; k++) begin
      if (n_done != base_done || n_coll != base_coll) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "sda_low", int'(sda_low), 0);
    chk("R1", "scl_low", int'(scl_low), 0);
    chk("R1", "request bits", int'({start_bit, rstart_bit}), 0);
    chk("R1", "brg_run", int'(brg_run), 0);
    chk("R1", "flags", int'({start_seen, done_irq, bus_coll, wcol, buf_wr_ok}), 0);
  endtask

  task automatic t_start_ok();
    int t_fall = 0, t_done = 0, bs, bd, bc;
    do_reset();
    bs = n_seen; bd = n_done; bc = n_coll;
    pulse_start();
    chk("R2", "start_bit set", int'(start_bit), 1);
    t_fall = 1;
    while (!sda_low && t_fall < 200) begin @(negedge clk); t_fall++; end
    chk("R2", "SCL released at SDA fall", int'(scl_low), 0);
    chk("R2", "SCL line high at SDA fall", int'(scl_line), 1);
    chk_ge("R2", "cycles to SDA fall", t_fall, PER);
    while (n_done == bd && t_done < 200) begin @(negedge clk); t_done++; end
    chk_ge("R3", "cycles SDA low before done", t_done, PER);
    repeat (2) @(negedge clk);
    chk("R3", "SDA held low", int'(sda_low), 1);
    chk("R3", "SCL released", int'(scl_low), 0);
    chk("R3", "start_bit cleared", int'(start_bit), 0);
    chk("R3", "divider suspended", int'(brg_run), 0);
    chk("R3", "done pulses", n_done - bd, 1);
    chk("R11", "start edges seen", n_seen - bs, 1);
    chk("R2", "no collision", n_coll - bc, 0);
  endtask

  task automatic t_start_coll(input logic hold_scl);
    int bd, bc;
    do_reset();
    bd = n_done; bc = n_coll;
    slv_sda = 1'b1; slv_scl = hold_scl;
    repeat (4) @(negedge clk);
    pulse_start();
    wait_end(bd, bc);
    chk("R4", "collision pulses", n_coll - bc, 1);
    chk("R4", "no done", n_done - bd, 0);
    chk("R4", "lines released", int'({sda_low, scl_low}), 0);
    chk("R4", "start_bit cleared", int'(start_bit), 0);
    slv_sda = 1'b0; slv_scl = 1'b0;
  endtask

  task automatic t_setup_scl_drop();
    int bd, bc;
    do_reset();
    bd = n_done; bc = n_coll;
    pulse_start();
    @(negedge clk);
    slv_scl = 1'b1;
    wait_end(bd, bc);
    chk("R5", "collision on SCL low in setup", n_coll - bc, 1);
    chk("R5", "no done", n_done - bd, 0);
    chk("R5", "SDA never driven", int'(sda_low), 0);
    slv_scl = 1'b0;
  endtask

  task automatic start_only();
    int bd, bc;
    bd = n_done; bc = n_coll;
    pulse_start();
    wait_end(bd, bc);
  endtask

  task automatic t_rstart_ok();
    int bs, bd, bc, run_bad = 0, k;
    do_reset();
    start_only();
    bs = n_seen; bd = n_done; bc = n_coll;
    pulse_rstart();
    k = 0;
    while (!scl_low && k < 50) begin @(negedge clk); k++; end
    chk("R6", "SDA still driven when SCL pulled", int'(sda_low), 1);
    slv_scl = 1'b1;
    k = 0;
    while (sda_low && k < 50) begin @(negedge clk); k++; end
    chk("R6", "SCL low when SDA released", int'(scl_low), 1);
    k = 0;
    while (scl_low && k < 100) begin @(negedge clk); k++; end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (brg_run) run_bad++;
    end
    chk("R7", "divider suspended while SCL stretched", run_bad, 0);
    chk("R7", "no done during stretch", n_done - bd, 0);
    slv_scl = 1'b0;
    wait_end(bd, bc);
    chk("R7", "done pulses", n_done - bd, 1);
    chk("R7", "rstart_bit cleared", int'(rstart_bit), 0);
    chk("R7", "end lines", int'({sda_low, scl_low}), 2);
    chk("R11", "repeated start edge seen", n_seen - bs, 1);
    chk("R7", "no collision", n_coll - bc, 0);
  endtask

  task automatic t_rstart_sda_stuck();
    int bd, bc;
    do_reset();
    start_only();
    bd = n_done; bc = n_coll;
    pulse_rstart();
    slv_sda = 1'b1;
    wait_end(bd, bc);
    chk("R8", "collision on SDA low after release", n_coll - bc, 1);
    chk("R8", "lines released", int'({sda_low, scl_low}), 0);
    chk("R8", "rstart_bit cleared", int'(rstart_bit), 0);
    slv_sda = 1'b0;
  endtask

  task automatic t_rstart_sda_on_rise();
    int bd, bc, k;
    do_reset();
    start_only();
    bd = n_done; bc = n_coll;
    pulse_rstart();
    k = 0;
    while (!scl_low && k < 50) begin @(negedge clk); k++; end
    slv_scl = 1'b1;
    k = 0;
    while (scl_low && k < 100) begin @(negedge clk); k++; end
    slv_sda = 1'b1;
    repeat (4) @(negedge clk);
    slv_scl = 1'b0;
    wait_end(bd, bc);
    chk("R8", "collision on SDA low at SCL rise", n_coll - bc, 1);
    chk("R8", "no done", n_done - bd, 0);
    slv_sda = 1'b0;
  endtask

  task automatic t_ignore();
    int bd, bc, rbad = 0;
    do_reset();
    bd = n_done; bc = n_coll;
    pulse_start();
    rstart_set = 1'b1; start_set = 1'b1;
    @(negedge clk);
    rstart_set = 1'b0; start_set = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (rstart_bit) rbad++;
      @(negedge clk);
    end
    chk("R9", "rstart ignored while busy", rbad, 0);
    chk("R9", "single done", n_done - bd, 1);
    do_reset();
    start_set = 1'b1; rstart_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0; rstart_set = 1'b0;
    chk("R9", "start wins tie", int'({start_bit, rstart_bit}), 2);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_wcol();
    int bw, bo;
    do_reset();
    bw = n_wcol; bo = n_wrok;
    buf_wr = 1'b1; @(negedge clk); buf_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "idle write accepted", n_wrok - bo, 1);
    chk("R10", "idle write no wcol", n_wcol - bw, 0);
    bw = n_wcol; bo = n_wrok;
    pulse_start();
    @(negedge clk);
    buf_wr = 1'b1; @(negedge clk); buf_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "busy write flagged", n_wcol - bw, 1);
    chk("R10", "busy write not forwarded", n_wrok - bo, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_seen();
    int bs, k;
    do_reset();
    bs = n_seen;
    slv_sda = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!start_seen && k < 10);
    chk("R12", "start_seen latency", k, SYNC + 1);
    repeat (3) @(negedge clk);
    chk("R11", "external start seen once", n_seen - bs, 1);
    bs = n_seen;
    slv_scl = 1'b1; repeat (4) @(negedge clk);
    slv_sda = 1'b0; repeat (4) @(negedge clk);
    slv_sda = 1'b1; repeat (6) @(negedge clk);
    chk("R11", "SDA fall with SCL low ignored", n_seen - bs, 0);
    slv_scl = 1'b0; repeat (4) @(negedge clk);
    slv_sda = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_start_ok();
    t_start_coll(1'b0);
    t_start_coll(1'b1);
    t_setup_scl_drop();
    t_rstart_ok();
    t_rstart_sda_stuck();
    t_rstart_sda_on_rise();
    t_ignore();
    t_wcol();
    t_seen();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule